// File: doc/BRIEF.md
# Fuse Array Command and Status Registers

This block is the register front end of a one-time-programmable fuse array. Software reaches it over a simple word-wide register bus. It holds one control word, with plain, bit-set and bit-clear views. It also holds a program-data register and a window of shadow words that mirror the fuse contents. An accepted program request goes out to a fuse programming engine. A shadow-refresh request goes out to a reload engine. Each engine reports back with a done pulse.

Programming is guarded in two ways. A 16-bit key must sit in the control word each time a program is attempted, and each attempt wipes that key. Per-word lock vectors come in from outside. Any forbidden access raises a sticky ERROR flag, and the access itself has no effect. While ERROR stays set, further program and reload requests are refused until software clears the flag. Reads return data in the cycle the read is presented.

Top module: `otp_cmd_regs`

## Requirements
- R1: After reset the control word reads 0, the data register and every shadow word read 0, and neither engine start pulse is asserted.
- R2: The control word at 0x000 is laid out as {key[31:16], 5'b0, reload bit 10, ERROR bit 9, BUSY bit 8, address [7:0]}. A plain write loads the address and key. Writing to 0x004 ORs ones into them, and writing to 0x008 clears the bits written as ones. Software cannot write BUSY or ERROR except as R9 allows.
- R3: A write to the data register at 0x010 starts a program when the key field equals 0x3E77, BUSY and ERROR are clear, and the addressed word is programmable. One cycle later progStart pulses for one cycle, BUSY reads 1, the key field reads 0, progAddr shows the address and progData shows the written value.
- R4: A data write while the key is not 0x3E77 stores the value in the data register, starts nothing and leaves the key unchanged.
- R5: While BUSY is set, writes to the address field do not change progAddr, and writes to the data register are dropped.
- R6: A program attempt on a word whose progLock bit is set, or on an address at or above NUM_WORDS, starts nothing and leaves BUSY clear. It sets ERROR and clears the key.
- R7: Shadow word i is at 0x400 + 4*i. A read of a word whose readLock bit is set returns 0xBADABADA and sets ERROR. Any other shadow read returns the stored word.
- R8: A bus write to a shadow word whose shadowLock bit is set, or any shadow write while a reload runs, sets ERROR and leaves the word unchanged. Any other shadow write stores the value.
- R9: ERROR stays set until a 1 is written to bit 9 through 0x008. While it is set, program and reload requests are not started.
- R10: Writing a 1 to bit 10 through 0x000 or 0x004 while idle and error-free sets bit 10 and BUSY and pulses reloadStart for one cycle. The reload engine loads shadows through shLoadEn. reloadDone clears bit 10 and BUSY.
- R11: A program or reload request made while BUSY is set is ignored. This includes a request made in the same cycle as the done pulse that ends the operation.
- R12: progDone clears BUSY at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | BUS_AW | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| progLock | input | NUM_WORDS | Per-word program lock |
| readLock | input | NUM_WORDS | Per-word read lock |
| shadowLock | input | NUM_WORDS | Per-word shadow write lock |
| progStart | output | 1 | One-cycle program start pulse |
| progAddr | output | 8 | Word address captured at program start |
| progData | output | 32 | Data register contents |
| progDone | input | 1 | Programming engine finished |
| reloadStart | output | 1 | One-cycle reload start pulse |
| reloadDone | input | 1 | Reload engine finished |
| shLoadEn | input | 1 | Reload engine shadow load |
| shLoadIdx | input | IDX_W | Shadow word being loaded |
| shLoadData | input | 32 | Value being loaded |

## Verification
A completion pulse from an engine and a fresh request from the bus can arrive in the same cycle. The bench provokes this by holding progDone high during the same clock as a reload request through the set view. It then reads the control word back. It requires BUSY and the reload bit to be clear and reloadStart to stay low, and it requires a reload issued afterwards to start normally. A second overlap is tested as well: a shadow write lands during a reload, ERROR is raised while the reload is still busy, and the shadow word is checked to be unchanged once the reload completes.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_MARK = 32'hBADABADA;
  localparam int OFS_CTRL   = 'h000;
  localparam int OFS_SET    = 'h004;
  localparam int OFS_CLR    = 'h008;
  localparam int OFS_DATA   = 'h010;
  localparam int OFS_SHADOW = 'h400;

  typedef enum logic [2:0] {RD_ZERO, RD_CTRL, RD_DATA, RD_SHADOW, RD_MARKER} rdSel_e;

  typedef struct packed {
    logic   dataWe;
    logic   shWe;
    rdSel_e rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int BUS_AW    = 12,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [7:0]           wAddrField,
  input  logic [2:0]           wFlagField,
  input  logic [15:0]          wKeyField,
  input  logic [NUM_WORDS-1:0] progLock,
  input  logic [NUM_WORDS-1:0] readLock,
  input  logic [NUM_WORDS-1:0] shadowLock,
  input  logic                 progDone,
  input  logic                 reloadDone,
  output logic [31:0]          ctrlWord,
  output logic                 busy,
  output dpStrobe_t            strobe,
  output logic                 progStart,
  output logic                 reloadStart,
  output logic [7:0]           progAddr
);
  logic [7:0]  addrQ, snapQ;
  logic [15:0] keyQ;
  logic        busyQ, errQ, reloadQ, progStartQ, reloadStartQ;

  logic wrCtrl, wrSet, wrClr, wrData, shHit, wrSh;
  logic [IDX_W-1:0] shIdx;
  logic keyOk, wordOk, progTry, progGo, progBad, reloadGo;
  logic shBad, rdBad, errSet, errClr;

  always_comb begin
    wrCtrl = busWr && (int'(busAddr) == OFS_CTRL);
    wrSet  = busWr && (int'(busAddr) == OFS_SET);
    wrClr  = busWr && (int'(busAddr) == OFS_CLR);
    wrData = busWr && (int'(busAddr) == OFS_DATA);
    shHit  = (int'(busAddr) >= OFS_SHADOW) && (int'(busAddr) < OFS_SHADOW + 4 * NUM_WORDS)
             && (busAddr[1:0] == 2'b00);
    shIdx  = busAddr[IDX_W+1:2];
    wrSh   = busWr && shHit;

    keyOk    = (keyQ == UNLOCK_KEY);
    wordOk   = (int'(addrQ) < NUM_WORDS) && !progLock[addrQ[IDX_W-1:0]];
    progTry  = wrData && keyOk && !busyQ && !errQ;
    progGo   = progTry && wordOk;
    progBad  = progTry && !wordOk;
    reloadGo = (wrCtrl || wrSet) && wFlagField[2] && !busyQ && !errQ;

    shBad  = wrSh && (reloadQ || shadowLock[shIdx]);
    rdBad  = busRd && shHit && readLock[shIdx];
    errSet = progBad || shBad || rdBad;
    errClr = wrClr && wFlagField[1];

    strobe.dataWe = wrData && !busyQ;
    strobe.shWe   = wrSh && !shBad;
    if (int'(busAddr) == OFS_CTRL || int'(busAddr) == OFS_SET || int'(busAddr) == OFS_CLR)
      strobe.rdSel = RD_CTRL;
    else if (int'(busAddr) == OFS_DATA)
      strobe.rdSel = RD_DATA;
    else if (shHit)
      strobe.rdSel = readLock[shIdx] ? RD_MARKER : RD_SHADOW;
    else
      strobe.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; keyQ <= '0; snapQ <= '0;
      busyQ <= 1'b0; errQ <= 1'b0; reloadQ <= 1'b0;
      progStartQ <= 1'b0; reloadStartQ <= 1'b0;
    end else begin
      if (wrCtrl) begin
        addrQ <= wAddrField; keyQ <= wKeyField;
      end else if (wrSet) begin
        addrQ <= addrQ | wAddrField; keyQ <= keyQ | wKeyField;
      end else if (wrClr) begin
        addrQ <= addrQ & ~wAddrField; keyQ <= keyQ & ~wKeyField;
      end else if (progTry) begin
        keyQ <= '0;
      end

      if (progGo || reloadGo)          busyQ <= 1'b1;
      else if (progDone || reloadDone) busyQ <= 1'b0;

      if (reloadGo)        reloadQ <= 1'b1;
      else if (reloadDone) reloadQ <= 1'b0;

      if (errSet)      errQ <= 1'b1;
      else if (errClr) errQ <= 1'b0;

      if (progGo) snapQ <= addrQ;
      progStartQ   <= progGo;
      reloadStartQ <= reloadGo;
    end
  end

  assign ctrlWord    = {keyQ, 5'b0, reloadQ, errQ, busyQ, addrQ};
  assign busy        = busyQ;
  assign progStart   = progStartQ;
  assign reloadStart = reloadStartQ;
  assign progAddr    = snapQ;

  p_start_key_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    progStartQ |-> (keyQ == 16'h0) && busyQ);
  p_no_start_when_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> !(progStartQ || reloadStartQ));
  p_snapshot_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> $stable(snapQ));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !(wrClr && wFlagField[1])) |=> errQ);
  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> !(progStartQ || reloadStartQ));
  p_reload_implies_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    reloadQ |-> busyQ);
endmodule

// File: rtl/otp_cmd_dp.sv
module otp_cmd_dp
  import otp_cmd_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [IDX_W-1:0] shIdx,
  input  logic [31:0]      busWdata,
  input  logic [31:0]      ctrlWord,
  input  logic             busy,
  input  logic             shLoadEn,
  input  logic [IDX_W-1:0] shLoadIdx,
  input  logic [31:0]      shLoadData,
  output logic [31:0]      busRdata,
  output logic [31:0]      dataOut
);
  logic [31:0] dataQ;
  logic [31:0] shadowQ [NUM_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (strobe.dataWe) dataQ <= busWdata;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      shadowQ[g] <= '0;
      else if (shLoadEn && shLoadIdx == IDX_W'(g))    shadowQ[g] <= shLoadData;
      else if (strobe.shWe && shIdx == IDX_W'(g))     shadowQ[g] <= busWdata;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CTRL:   busRdata = ctrlWord;
      RD_DATA:   busRdata = dataQ;
      RD_SHADOW: busRdata = shadowQ[shIdx];
      RD_MARKER: busRdata = LOCKED_MARK;
      default:   busRdata = '0;
    endcase
  end

  assign dataOut = dataQ;

  p_data_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dataQ));
endmodule

// File: rtl/otp_cmd_regs.sv
module otp_cmd_regs
  import otp_cmd_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int BUS_AW    = 12,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [BUS_AW-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_WORDS-1:0] progLock,
  input  logic [NUM_WORDS-1:0] readLock,
  input  logic [NUM_WORDS-1:0] shadowLock,
  output logic                 progStart,
  output logic [7:0]           progAddr,
  output logic [31:0]          progData,
  input  logic                 progDone,
  output logic                 reloadStart,
  input  logic                 reloadDone,
  input  logic                 shLoadEn,
  input  logic [IDX_W-1:0]     shLoadIdx,
  input  logic [31:0]          shLoadData
);
  dpStrobe_t   strobe;
  logic [31:0] ctrlWord;
  logic        busy;

  otp_cmd_ctrl #(.NUM_WORDS(NUM_WORDS), .BUS_AW(BUS_AW), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rstN, .busWr, .busRd, .busAddr,
    .wAddrField(busWdata[7:0]), .wFlagField(busWdata[10:8]), .wKeyField(busWdata[31:16]),
    .progLock, .readLock, .shadowLock, .progDone, .reloadDone,
    .ctrlWord, .busy, .strobe, .progStart, .reloadStart, .progAddr
  );

  otp_cmd_dp #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dp (
    .clk, .rstN, .strobe, .shIdx(busAddr[IDX_W+1:2]), .busWdata, .ctrlWord, .busy,
    .shLoadEn, .shLoadIdx, .shLoadData, .busRdata, .dataOut(progData)
  );
endmodule

// File: tb/otp_cmd_regs_test.sv
module otp_cmd_regs_test;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 0, rstN = 0, busWr = 0, busRd = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [N-1:0] progLock, readLock, shadowLock;
  logic progStart, reloadStart, progDone = 0, reloadDone = 0, shLoadEn = 0;
  logic [7:0] progAddr;
  logic [31:0] progData, shLoadData = '0;
  logic [IW-1:0] shLoadIdx = '0;

  int nChecks = 0, nErr = 0;
  logic [31:0] model [N];

  always #5 clk = ~clk;

  otp_cmd_regs uut (.clk, .rstN, .busWr, .busRd, .busAddr, .busWdata, .busRdata,
    .progLock, .readLock, .shadowLock, .progStart, .progAddr, .progData, .progDone,
    .reloadStart, .reloadDone, .shLoadEn, .shLoadIdx, .shLoadData);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); busWr = 1; busAddr = 12'(a); busWdata = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); busRd = 1; busAddr = 12'(a);
    #1 v = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic pulseProgDone();
    @(negedge clk); progDone = 1; @(negedge clk); progDone = 0;
  endtask

  task automatic pulseReloadDone();
    @(negedge clk); reloadDone = 1; @(negedge clk); reloadDone = 0;
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] k, input logic r, e, b, input logic [7:0] a);
    return {k, 5'b0, r, e, b, a};
  endfunction

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [31:0] v, d;
    for (int i = 0; i < N; i++) begin
      progLock[i]   = (i % 3 == 0);
      shadowLock[i] = (i % 4 == 1);
      readLock[i]   = (i % 5 == 2);
      model[i]      = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk("R1 progStart", 32'(progStart), 0);
    chk("R1 reloadStart", 32'(reloadStart), 0);
    rd('h000, v); chk("R1 ctrl", v, 0);
    rd('h010, v); chk("R1 data", v, 0);
    for (int i = 0; i < N; i++) if (!readLock[i]) begin
      rd('h400 + 4*i, v); chk("R1 shadow", v, 0);
    end

    // R2 aliases
    wr('h000, 32'hABCD_03A5); rd('h000, v); chk("R2 plain", v, 32'hABCD_00A5);
    wr('h004, 32'h1250_0342); rd('h000, v); chk("R2 set", v, 32'hBBDD_00E7);
    wr('h008, 32'h0F0F_0003); rd('h000, v); chk("R2 clr", v, 32'hB0D0_00E4);
    wr('h008, 32'hFFFF_00FF); rd('h000, v); chk("R2 clr all", v, 0);

    // R4 wrong key
    wr('h000, 32'h3E76_0002); wr('h010, 32'h0000_DEAD);
    chk("R4 no start", 32'(progStart), 0);
    rd('h010, v); chk("R4 data stored", v, 32'h0000_DEAD);
    rd('h000, v); chk("R4 key kept", v, 32'h3E76_0002);

    // R3 R5 R6 R9 R12 sweep over all addresses and two past the end
    for (int a = 0; a < N + 2; a++) begin
      d = 32'h1000_0000 + 32'(a * 7);
      wr('h000, {16'h3E77, 8'h0, 8'(a)});
      wr('h010, d);
      if (a < N && (a % 3 != 0)) begin
        chk("R3 start", 32'(progStart), 1);
        chk("R3 addr", 32'(progAddr), 32'(a));
        chk("R3 data", progData, d);
        rd('h000, v); chk("R3 busy key cleared", v, ctl(16'h0, 0, 0, 1, 8'(a)));
        wr('h000, {16'h3E77, 8'h0, 8'(a) ^ 8'h5A});
        wr('h010, 32'hFFFF_FFFF);
        chk("R5 no restart", 32'(progStart), 0);
        chk("R5 addr held", 32'(progAddr), 32'(a));
        rd('h010, v); chk("R5 data held", v, d);
        pulseProgDone();
        rd('h000, v); chk("R12 busy cleared", v, ctl(16'h3E77, 0, 0, 0, 8'(a) ^ 8'h5A));
      end else begin
        chk("R6 no start", 32'(progStart), 0);
        rd('h000, v); chk("R6 err set", v, ctl(16'h0, 0, 1, 0, 8'(a)));
        wr('h000, 32'h3E77_0001); wr('h010, 32'h0000_0055);
        chk("R9 prog blocked", 32'(progStart), 0);
        wr('h004, 32'h0000_0400);
        chk("R9 reload blocked", 32'(reloadStart), 0);
        rd('h000, v); chk("R9 still err", v, 32'h3E77_0201);
        wr('h008, 32'h0000_0200);
        rd('h000, v); chk("R9 err cleared", v, 32'h3E77_0001);
      end
    end

    // R8 shadow writes, R7 shadow reads
    wr('h000, 32'h0);
    for (int i = 0; i < N; i++) begin
      d = 32'hA000_0000 | 32'(i << 8) | 32'(i);
      wr('h400 + 4*i, d);
      rd('h000, v);
      if (shadowLock[i]) begin
        chk("R8 locked write err", v, 32'h0000_0200);
        wr('h008, 32'h0000_0200);
      end else begin
        chk("R8 write ok", v, 0);
        model[i] = d;
      end
    end
    for (int i = 0; i < N; i++) begin
      rd('h400 + 4*i, v);
      if (readLock[i]) begin
        chk("R7 marker", v, 32'hBADA_BADA);
        rd('h000, v); chk("R7 err", v, 32'h0000_0200);
        wr('h008, 32'h0000_0200);
      end else begin
        chk("R7 data", v, model[i]);
      end
    end

    // R10 reload, R8 write during reload
    wr('h004, 32'h0000_0400);
    chk("R10 reloadStart", 32'(reloadStart), 1);
    rd('h000, v); chk("R10 busy+bit", v, 32'h0000_0500);
    wr('h400, 32'h1234_5678);
    rd('h000, v); chk("R8 write in reload err", v, 32'h0000_0700);
    wr('h004, 32'h0000_0400);
    chk("R11 reload while busy", 32'(reloadStart), 0);
    @(negedge clk); shLoadEn = 1; shLoadIdx = IW'(3); shLoadData = 32'h5555_0003;
    @(negedge clk); shLoadEn = 0;
    model[3] = 32'h5555_0003;
    pulseReloadDone();
    rd('h000, v); chk("R10 done", v, 32'h0000_0200);
    rd('h40C, v); chk("R10 loaded", v, model[3]);
    rd('h400, v); chk("R8 unchanged", v, model[0]);
    wr('h004, 32'h0000_0400);
    chk("R9 reload blocked", 32'(reloadStart), 0);
    wr('h008, 32'h0000_0200);
    rd('h000, v); chk("R9 cleared", v, 0);

    // R11 done and request in the same cycle
    wr('h000, 32'h3E77_0001); wr('h010, 32'h0000_0077);
    chk("R3 start word1", 32'(progStart), 1);
    @(negedge clk); progDone = 1; busWr = 1; busAddr = 12'h004; busWdata = 32'h0000_0400;
    @(negedge clk); progDone = 0; busWr = 0;
    chk("R11 collision no start", 32'(reloadStart), 0);
    rd('h000, v); chk("R11 collision ctrl", v, 32'h0000_0001);
    wr('h004, 32'h0000_0400);
    chk("R10 reload after", 32'(reloadStart), 1);
    pulseReloadDone();
    rd('h000, v); chk("R10 idle again", v, 32'h0000_0001);

    finish();
  end
endmodule